// File: doc/BRIEF.md
# System Clock Source Switch with Crystal Failover

This controller picks which of three oscillators drives the system clock: the internal RC oscillator, the external crystal oscillator, or the PLL. Software writes a two-bit select code. The controller keeps the current source running until the requested source is both enabled and reporting stable, and only then makes the switch. It also holds the effective enable of each oscillator. An enable request is refused when it would stop a source that is in use.

The block runs on the internal RC clock. It samples the crystal clock through a synchronizer. When monitoring is on, a crystal clock that stops toggling is taken as a failure. On a failure the controller disables the crystal, sets a sticky stuck flag, and pulses a non-maskable event. If the crystal was driving the system clock, or was feeding an enabled PLL, the controller also forces the system clock back to the RC source and turns the PLL off.

The controller is a two-state machine. `ST_RUN` means no switch is waiting. `ST_PEND` means a switch is waiting for its target. The transitions are:
- request: `ST_RUN` to `ST_PEND`, on a valid select write that differs from the active source.
- retarget: `ST_PEND` to `ST_PEND`, when a new write replaces the target.
- cancel: `ST_PEND` to `ST_RUN`, when a write names the active source.
- commit: `ST_PEND` to `ST_RUN`, when the target is ready and the active source takes the target's value.
- fallback: any state to `ST_RUN`, on a forced fallback, with the RC source made active.

Top module: `clksw_ctrl`

## Requirements
- R1: After reset, `active_src` and `sel_rd` read 0 (RC) and `irc_en` is 1. `xtal_en`, `pll_en`, `switching`, `stuck_flag` and `nmi_evt` are all 0.
- R2: The select codes are 0 for RC, 1 for crystal and 2 for PLL. Code 3 is ignored. A write of a valid code that differs from the active source makes `switching` 1, and `sel_rd` then shows the requested code.
- R3: A pending switch completes in the cycle after its target is both enabled and stable. Until then `active_src` keeps the previous source.
- R4: A select write made while a switch is pending replaces the target. A write that names the active source cancels the pending switch.
- R5: An enable write uses `en_data` bit 0 for RC, bit 1 for crystal and bit 2 for PLL. A clear is ignored for any source that is active, and for the source feeding an enabled PLL, where `pll_src` 0 means RC and 1 means crystal. All other bits are written as given.
- R6: Monitoring runs only while `mon_en` and `xtal_en` are both 1. A failure is declared after 16 RC cycles in which no synchronized crystal edge is seen. A toggling crystal raises no failure, and disabled monitoring never raises one.
- R7: A failure clears `xtal_en`, sets `stuck_flag`, and produces exactly one single-cycle pulse on `nmi_evt`.
- R8: A failure while the crystal is active or feeds an enabled PLL has these effects: `active_src` becomes RC, any pending switch is dropped, `sel_rd` reads RC, `pll_en` is cleared and `irc_en` is set. A failure while the crystal is unused leaves `active_src` and `pll_en` unchanged.
- R9: `stuck_flag` stays set until a `stuck_clr` strobe clears it. If a new failure occurs in the same cycle as the strobe, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal RC clock; all state is clocked by it |
| rst_n | input | 1 | Active-low reset |
| sel_wr | input | 1 | Select write strobe |
| sel_data | input | 2 | Requested source code |
| en_wr | input | 1 | Enable write strobe |
| en_data | input | 3 | Requested enables {PLL, crystal, RC} |
| pll_src | input | 1 | PLL input: 0 = RC, 1 = crystal |
| mon_en | input | 1 | Crystal failure monitor enable |
| stuck_clr | input | 1 | Clears the stuck flag |
| irc_stable | input | 1 | RC oscillator stable |
| xtal_stable | input | 1 | Crystal oscillator stable |
| pll_stable | input | 1 | PLL locked |
| xtal_clk | input | 1 | Raw crystal clock, asynchronous |
| active_src | output | 2 | Source currently driving the system clock |
| sel_rd | output | 2 | Select readback (the pending target while a switch waits) |
| switching | output | 1 | A switch is pending |
| irc_en | output | 1 | Effective RC enable |
| xtal_en | output | 1 | Effective crystal enable |
| pll_en | output | 1 | Effective PLL enable |
| stuck_flag | output | 1 | Sticky crystal failure flag |
| nmi_evt | output | 1 | One-cycle failure event |

## Verification
The assertions assume that every strobe lasts one RC cycle and that `pll_src` is stable around each enable write. They also assume that the crystal clock, while running, toggles at least once every few RC cycles, so that a running crystal never looks failed. The stimulus changes inputs only between clock edges. It runs the crystal at about 1.4 RC cycles per edge, stops it outright to cause failures, and sets up the stable inputs before each select write that depends on them.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
    typedef enum logic [1:0] {
        SRC_IRC  = 2'd0,
        SRC_XTAL = 2'd1,
        SRC_PLL  = 2'd2,
        SRC_RSVD = 2'd3
    } clk_src_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_PEND = 1'b1
    } sw_state_e;

    localparam int unsigned EN_IRC  = 0;
    localparam int unsigned EN_XTAL = 1;
    localparam int unsigned EN_PLL  = 2;
    localparam int unsigned N_SRC   = 3;
endpackage

// File: rtl/clksw_xtal_mon.sv
module clksw_xtal_mon #(
    parameter int unsigned MON_LIMIT   = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic xtal_clk,
    output logic fail
);
    localparam int unsigned CW = (MON_LIMIT > 2) ? $clog2(MON_LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(MON_LIMIT - 1);

    logic [SYNC_STAGES:0] sync_q;
    logic [CW-1:0]        gap_cnt;
    logic                 edge_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], xtal_clk};
    end

    assign edge_seen = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   gap_cnt <= '0;
        else if (!arm || edge_seen)   gap_cnt <= '0;
        else if (gap_cnt == LAST)     gap_cnt <= '0;
        else                          gap_cnt <= gap_cnt + 1'b1;
    end

    assign fail = arm && !edge_seen && (gap_cnt == LAST);

    // R7
    fail_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !fail);

    // R6
    edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && edge_seen) |=> !fail);
endmodule

// File: rtl/clksw_en_guard.sv
module clksw_en_guard
    import clksw_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_wr,
    input  logic [N_SRC-1:0] en_data,
    input  clk_src_e     active,
    input  logic         pll_src,
    input  logic         fail,
    input  logic         force_fb,
    output logic [N_SRC-1:0] en_q
);
    logic [N_SRC-1:0] lock;
    logic [N_SRC-1:0] en_nxt;

    always_comb begin
        lock[EN_IRC]  = (active == SRC_IRC)  || (en_q[EN_PLL] && !pll_src);
        lock[EN_XTAL] = (active == SRC_XTAL) || (en_q[EN_PLL] &&  pll_src);
        lock[EN_PLL]  = (active == SRC_PLL);
    end

    always_comb begin
        en_nxt = en_q;
        if (en_wr) en_nxt = en_data | (lock & en_q);
        if (fail) en_nxt[EN_XTAL] = 1'b0;
        if (force_fb) begin
            en_nxt[EN_PLL] = 1'b0;
            en_nxt[EN_IRC] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= N_SRC'(1 << EN_IRC);
        else        en_q <= en_nxt;
    end

    // R5
    irc_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock[EN_IRC] && en_q[EN_IRC]) |=> en_q[EN_IRC]);

    // R5
    xtal_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock[EN_XTAL] && en_q[EN_XTAL] && !fail) |=> en_q[EN_XTAL]);

    // R5
    pll_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock[EN_PLL] && en_q[EN_PLL] && !force_fb) |=> en_q[EN_PLL]);
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
    import clksw_pkg::*;
#(
    parameter int unsigned MON_LIMIT   = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_wr,
    input  logic [1:0] sel_data,
    input  logic       en_wr,
    input  logic [2:0] en_data,
    input  logic       pll_src,
    input  logic       mon_en,
    input  logic       stuck_clr,
    input  logic       irc_stable,
    input  logic       xtal_stable,
    input  logic       pll_stable,
    input  logic       xtal_clk,
    output logic [1:0] active_src,
    output logic [1:0] sel_rd,
    output logic       switching,
    output logic       irc_en,
    output logic       xtal_en,
    output logic       pll_en,
    output logic       stuck_flag,
    output logic       nmi_evt
);
    sw_state_e        state, state_nxt;
    clk_src_e         active, active_nxt;
    clk_src_e         target, target_nxt;
    clk_src_e         req;
    logic [N_SRC-1:0] en_q;
    logic [3:0]       stable_vec;
    logic [3:0]       en_vec;
    logic             ready;
    logic             req_ok;
    logic             mon_fail;
    logic             xtal_used;
    logic             force_fb;

    assign req        = clk_src_e'(sel_data);
    assign req_ok     = sel_wr && (req != SRC_RSVD);
    assign stable_vec = {1'b0, pll_stable, xtal_stable, irc_stable};
    assign en_vec     = {1'b0, en_q};
    assign ready      = stable_vec[target] && en_vec[target];
    assign xtal_used  = (active == SRC_XTAL) || (pll_src && en_q[EN_PLL]);
    assign force_fb   = mon_fail && xtal_used;

    clksw_xtal_mon #(
        .MON_LIMIT  (MON_LIMIT),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (mon_en && en_q[EN_XTAL]),
        .xtal_clk(xtal_clk),
        .fail    (mon_fail)
    );

    clksw_en_guard u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_wr   (en_wr),
        .en_data (en_data),
        .active  (active),
        .pll_src (pll_src),
        .fail    (mon_fail),
        .force_fb(force_fb),
        .en_q    (en_q)
    );

    always_comb begin
        state_nxt  = state;
        active_nxt = active;
        target_nxt = target;
        if (force_fb) begin
            state_nxt  = ST_RUN;
            active_nxt = SRC_IRC;
            target_nxt = SRC_IRC;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (req_ok && req != active) begin
                        state_nxt  = ST_PEND;
                        target_nxt = req;
                    end
                end
                ST_PEND: begin
                    if (req_ok) begin
                        if (req == active) state_nxt = ST_RUN;
                        else               target_nxt = req;
                    end else if (ready) begin
                        active_nxt = target;
                        state_nxt  = ST_RUN;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_RUN;
            active <= SRC_IRC;
            target <= SRC_IRC;
        end else begin
            state  <= state_nxt;
            active <= active_nxt;
            target <= target_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stuck_flag <= 1'b0;
            nmi_evt    <= 1'b0;
        end else begin
            nmi_evt <= mon_fail;
            if (mon_fail)       stuck_flag <= 1'b1;
            else if (stuck_clr) stuck_flag <= 1'b0;
        end
    end

    always_comb begin
        active_src = active;
        switching  = (state == ST_PEND);
        sel_rd     = (state == ST_PEND) ? target : active;
        irc_en     = en_q[EN_IRC];
        xtal_en    = en_q[EN_XTAL];
        pll_en     = en_q[EN_PLL];
    end

    // R3
    hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PEND && !sel_wr && !force_fb && !ready) |=> (active_src == $past(active_src)));

    // R4
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PEND && req_ok && req == active && !force_fb) |=> !switching);

    // R7
    fail_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mon_fail |=> (stuck_flag && nmi_evt && !xtal_en));

    // R7
    nmi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_evt |=> !nmi_evt);

    // R8
    fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_fb |=> (active_src == SRC_IRC && !switching && !pll_en && irc_en));

    // R9
    stuck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stuck_flag && !stuck_clr) |=> stuck_flag);
endmodule

// File: tb/clksw_ctrl_test.sv
`timescale 1ns/100ps
module clksw_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_wr = 1'b0;
    logic [1:0] sel_data = 2'd0;
    logic       en_wr = 1'b0;
    logic [2:0] en_data = 3'd0;
    logic       pll_src = 1'b0;
    logic       mon_en = 1'b0;
    logic       stuck_clr = 1'b0;
    logic       irc_stable = 1'b1;
    logic       xtal_stable = 1'b0;
    logic       pll_stable = 1'b0;
    logic       xtal_clk = 1'b0;
    logic       xtal_run = 1'b1;
    logic [1:0] active_src, sel_rd;
    logic       switching, irc_en, xtal_en, pll_en, stuck_flag, nmi_evt;

    int n_cmp = 0;
    int n_bad = 0;
    int nmi_cnt = 0;
    int nmi_base = 0;

    always #2.5 clk = ~clk;
    always #7 if (xtal_run) xtal_clk = ~xtal_clk;
    always @(posedge clk) if (nmi_evt) nmi_cnt <= nmi_cnt + 1;

    clksw_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_data(sel_data),
        .en_wr(en_wr), .en_data(en_data), .pll_src(pll_src), .mon_en(mon_en),
        .stuck_clr(stuck_clr), .irc_stable(irc_stable), .xtal_stable(xtal_stable),
        .pll_stable(pll_stable), .xtal_clk(xtal_clk), .active_src(active_src),
        .sel_rd(sel_rd), .switching(switching), .irc_en(irc_en), .xtal_en(xtal_en),
        .pll_en(pll_en), .stuck_flag(stuck_flag), .nmi_evt(nmi_evt)
    );

    // rows: {sel[1:0], xtal_stable, pll_stable, expected active[1:0]}
    localparam logic [5:0] VEC [7] = '{
        6'b01_1_1_01,
        6'b10_1_1_10,
        6'b00_1_1_00,
        6'b11_1_1_00,
        6'b10_1_0_00,
        6'b01_1_0_01,
        6'b00_1_1_00
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_sel(input logic [1:0] v);
        sel_data = v; sel_wr = 1'b1; cyc(1); sel_wr = 1'b0;
    endtask

    task automatic wr_en(input logic [2:0] v);
        en_data = v; en_wr = 1'b1; cyc(1); en_wr = 1'b0;
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        report();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 active", 8'(active_src), 8'd0);
        chk("R1 sel_rd", 8'(sel_rd), 8'd0);
        chk("R1 enables", 8'({pll_en, xtal_en, irc_en}), 8'b001);
        chk("R1 flags", 8'({switching, stuck_flag, nmi_evt}), 8'd0);

        // R3 deferred switch: target not yet enabled/stable
        wr_sel(2'd2);
        cyc(3);
        chk("R2 pending", 8'({switching, sel_rd}), 8'b1_10);
        chk("R3 held", 8'(active_src), 8'd0);
        wr_en(3'b111);
        cyc(3);
        chk("R3 held unstable", 8'(active_src), 8'd0);
        pll_stable = 1'b1;
        cyc(1);
        chk("R3 commit", 8'({switching, active_src}), 8'b0_10);
        wr_sel(2'd0);
        cyc(2);

        // table: R2 R3 R4
        foreach (VEC[i]) begin
            xtal_stable = VEC[i][3];
            pll_stable  = VEC[i][2];
            wr_sel(VEC[i][5:4]);
            cyc(3);
            chk("R2/R3/R4 table", 8'(active_src), 8'(VEC[i][1:0]));
        end

        // R4 cancel
        xtal_stable = 1'b0;
        wr_sel(2'd1);
        cyc(1);
        chk("R4 pending", 8'(sel_rd), 8'd1);
        wr_sel(2'd0);
        chk("R4 cancel", 8'({switching, sel_rd}), 8'b0_00);
        xtal_stable = 1'b1;
        cyc(3);
        chk("R4 stays irc", 8'(active_src), 8'd0);

        // R5 lock rules: crystal active, PLL on fed by RC
        wr_sel(2'd1);
        cyc(3);
        chk("R5 setup", 8'(active_src), 8'd1);
        wr_en(3'b000);
        chk("R5 locked", 8'({pll_en, xtal_en, irc_en}), 8'b011);
        wr_en(3'b000);
        chk("R5 irc freed", 8'({pll_en, xtal_en, irc_en}), 8'b010);
        wr_en(3'b111);

        // R6 R7 R8 failure while crystal in use
        pll_src = 1'b1;
        mon_en = 1'b1;
        cyc(60);
        chk("R6 running xtal no fail", 8'(stuck_flag), 8'd0);
        nmi_base = nmi_cnt;
        xtal_run = 1'b0;
        cyc(40);
        chk("R7 stuck", 8'(stuck_flag), 8'd1);
        chk("R7 one nmi", 8'(nmi_cnt - nmi_base), 8'd1);
        chk("R8 fallback", 8'({active_src, sel_rd}), 8'b00_00);
        chk("R8 enables", 8'({pll_en, xtal_en, irc_en}), 8'b001);

        // R9 sticky then cleared
        cyc(10);
        chk("R9 sticky", 8'(stuck_flag), 8'd1);
        stuck_clr = 1'b1; cyc(1); stuck_clr = 1'b0;
        chk("R9 cleared", 8'(stuck_flag), 8'd0);

        // R6 monitor disabled: stopped crystal raises nothing
        mon_en = 1'b0;
        pll_src = 1'b0;
        wr_en(3'b111);
        cyc(40);
        chk("R6 disabled", 8'({stuck_flag, xtal_en}), 8'b01);

        // R8 failure while crystal unused
        nmi_base = nmi_cnt;
        mon_en = 1'b1;
        cyc(40);
        chk("R7 unused stuck", 8'({stuck_flag, xtal_en}), 8'b10);
        chk("R8 unused keeps", 8'({active_src, pll_en}), 8'b00_1);
        chk("R7 unused one nmi", 8'(nmi_cnt - nmi_base), 8'd1);

        report();
    end
endmodule